// File: doc/BRIEF.md
# Machine Trap Vector and Cause Unit

This block keeps the machine-level trap vector register, the trap cause register and the exception program-counter register of a 32-bit core. When the pipeline reports a trap, the block records the cause and the faulting PC. In the same clock edge it produces the address where instruction fetch must resume, and it pulses a redirect strobe for one cycle.

The two low bits of the vector register select the dispatch style. In direct style every trap goes to the base address. In vectored style an interrupt goes to the base plus four times its code, and a synchronous exception still goes to the base. A register write that asks for one of the two reserved styles stores the new base and keeps the old style. That write also raises a one-cycle illegal-write flag.

Software reaches the three registers through a small CSR port. Reads are registered, and an address that matches no register returns zero.

Top module: `trap_dispatch_unit`

## Requirements
- R1: After synchronous reset, the vector, cause and exception-PC registers all read as zero. `redirect_o`, `bad_mode_o` and `csr_rdata_o` are low.
- R2: A write to the vector register (address 0x305) whose data has bits [1:0] equal to 0 or 1 stores the whole 32-bit word. A read returns that word.
- R3: A write to the vector register whose data has bits [1:0] equal to 2 or 3 stores bits [31:2] and leaves bits [1:0] unchanged. `bad_mode_o` is high in the one cycle after that write and low in every other cycle.
- R4: With style 0, every trap gives a target equal to `{vector[31:2], 2'b00}`, and every target has bits [1:0] at zero.
- R5: With style 1 and the interrupt flag set, the target is `{vector[31:2], 2'b00} + 4 * code`, taken modulo 2^32.
- R6: With style 1 and the interrupt flag clear, the target is `{vector[31:2], 2'b00}`.
- R7: A trap sampled at a clock edge sets the cause register (address 0x342) to `{irq, code}`, with bit 31 as the type. It sets the exception-PC register (address 0x341) to the PC with bits [1:0] cleared. It also drives `redirect_o` high, with the target, for exactly the following cycle.
- R8: When a trap and a CSR write to the cause or exception-PC register share a cycle, the trap values are stored.
- R9: A read of any other address returns zero, and a write to any other address changes no register.
- R10: `csr_rdata_o` shows, one cycle later, the value that the addressed register held at the sampling edge.
- R11: A CSR write to the exception-PC register stores the data with bits [1:0] cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_we_i | input | 1 | CSR write enable |
| csr_rdata_o | output | 32 | Registered CSR read data |
| trap_i | input | 1 | Trap entry this cycle |
| trap_irq_i | input | 1 | Trap is an interrupt |
| trap_code_i | input | 31 | Exception code |
| trap_pc_i | input | 32 | PC of the trapping instruction |
| redirect_o | output | 1 | Fetch redirect strobe |
| redirect_pc_o | output | 32 | Fetch redirect target |
| bad_mode_o | output | 1 | Reserved-style write flag |

## Verification
All results appear exactly one clock edge after the inputs are sampled. This covers the redirect strobe, its target, the illegal-write flag and the read data. The register updates made by a trap or a write are seen in the read data of a read issued from the next cycle on. The bench drives inputs on the falling edge and predicts each result from a model of the registers as they stood before the rising edge. It then updates the model and compares at the next falling edge, so each comparison falls in the single cycle where its result is due.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;
  typedef enum logic [1:0] {
    STYLE_DIRECT   = 2'd0,
    STYLE_VECTORED = 2'd1
  } dispatch_style_e;
endpackage

// File: rtl/tv_vector_reg.sv
module tv_vector_reg #(
  parameter int          XLEN     = 32,
  parameter int          AW       = 12,
  parameter logic [AW-1:0] ADDR_VEC = 12'h305
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-3:0] base,
  output logic [1:0]      style,
  output logic            bad_mode
);
  logic hit;
  assign hit = we && (addr == ADDR_VEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      style    <= trapvec_pkg::STYLE_DIRECT;
      bad_mode <= 1'b0;
    end else begin
      bad_mode <= 1'b0;
      if (hit) begin
        base <= wdata[XLEN-1:2];
        // Styles 2 and 3 are reserved: keep the style, flag the write.
        if (wdata[1]) bad_mode <= 1'b1;
        else          style    <= wdata[1:0];
      end
    end
  end
endmodule

// File: rtl/tv_target_calc.sv
module tv_target_calc #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-3:0] base,
  input  logic [1:0]      style,
  input  logic            irq,
  input  logic [XLEN-3:0] code_lo,
  output logic [XLEN-1:0] target
);
  logic            offset_en;
  logic [XLEN-1:0] base_addr;
  logic [XLEN-1:0] offset;

  always_comb begin
    offset_en = (style == trapvec_pkg::STYLE_VECTORED) && irq;
    base_addr = {base, 2'b00};
    offset    = offset_en ? {code_lo, 2'b00} : '0;
    target    = base_addr + offset;
  end
endmodule

// File: rtl/tv_cause_epc.sv
module tv_cause_epc #(
  parameter int            XLEN       = 32,
  parameter int            AW         = 12,
  parameter logic [AW-1:0] ADDR_CAUSE = 12'h342,
  parameter logic [AW-1:0] ADDR_EPC   = 12'h341
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap,
  input  logic            irq,
  input  logic [XLEN-2:0] code,
  input  logic [XLEN-1:0] pc,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] epc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cause <= '0;
      epc   <= '0;
    end else if (trap) begin
      cause <= {irq, code};
      epc   <= {pc[XLEN-1:2], 2'b00};
    end else if (we) begin
      if (addr == ADDR_CAUSE) cause <= wdata;
      if (addr == ADDR_EPC)   epc   <= {wdata[XLEN-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/trap_dispatch_unit.sv
module trap_dispatch_unit #(
  parameter int            XLEN       = 32,
  parameter int            AW         = 12,
  parameter logic [AW-1:0] ADDR_VEC   = 12'h305,
  parameter logic [AW-1:0] ADDR_CAUSE = 12'h342,
  parameter logic [AW-1:0] ADDR_EPC   = 12'h341
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  input  logic            csr_we_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            trap_i,
  input  logic            trap_irq_i,
  input  logic [XLEN-2:0] trap_code_i,
  input  logic [XLEN-1:0] trap_pc_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            bad_mode_o
);
  logic [XLEN-3:0] vec_base;
  logic [1:0]      vec_style;
  logic [XLEN-1:0] cause_q;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] target_d;
  logic [XLEN-1:0] rdata_d;

  tv_vector_reg #(.XLEN(XLEN), .AW(AW), .ADDR_VEC(ADDR_VEC)) u_vec (
    .clk(clk), .rst(rst), .we(csr_we_i), .addr(csr_addr_i), .wdata(csr_wdata_i),
    .base(vec_base), .style(vec_style), .bad_mode(bad_mode_o)
  );

  tv_target_calc #(.XLEN(XLEN)) u_calc (
    .base(vec_base), .style(vec_style), .irq(trap_irq_i),
    .code_lo(trap_code_i[XLEN-3:0]), .target(target_d)
  );

  tv_cause_epc #(.XLEN(XLEN), .AW(AW), .ADDR_CAUSE(ADDR_CAUSE), .ADDR_EPC(ADDR_EPC)) u_ce (
    .clk(clk), .rst(rst), .trap(trap_i), .irq(trap_irq_i), .code(trap_code_i),
    .pc(trap_pc_i), .we(csr_we_i), .addr(csr_addr_i), .wdata(csr_wdata_i),
    .cause(cause_q), .epc(epc_q)
  );

  always_comb begin
    if (csr_addr_i == ADDR_VEC)        rdata_d = {vec_base, vec_style};
    else if (csr_addr_i == ADDR_CAUSE) rdata_d = cause_q;
    else if (csr_addr_i == ADDR_EPC)   rdata_d = epc_q;
    else                               rdata_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      csr_rdata_o   <= '0;
    end else begin
      redirect_o    <= trap_i;
      redirect_pc_o <= trap_i ? target_d : redirect_pc_o;
      csr_rdata_o   <= rdata_d;
    end
  end
endmodule

// File: rtl/trap_dispatch_unit_checker.sv
module trap_dispatch_unit_checker #(
  parameter int            XLEN       = 32,
  parameter int            AW         = 12,
  parameter logic [AW-1:0] ADDR_VEC   = 12'h305,
  parameter logic [AW-1:0] ADDR_CAUSE = 12'h342,
  parameter logic [AW-1:0] ADDR_EPC   = 12'h341
) (
  input logic            clk,
  input logic            rst,
  input logic [AW-1:0]   csr_addr,
  input logic            csr_we,
  input logic            wmode_hi,
  input logic            trap,
  input logic            redirect,
  input logic [1:0]      redirect_lo,
  input logic            bad_mode,
  input logic [XLEN-1:0] rdata
);
  logic reserved_wr;
  logic unmapped;
  assign reserved_wr = csr_we && (csr_addr == ADDR_VEC) && wmode_hi;
  assign unmapped    = (csr_addr != ADDR_VEC) && (csr_addr != ADDR_CAUSE) && (csr_addr != ADDR_EPC);

  assert_redirect_pulse_R7: assert property (@(posedge clk) disable iff (rst) trap |=> redirect);
  assert_redirect_idle_R7:  assert property (@(posedge clk) disable iff (rst) !trap |=> !redirect);
  assert_bad_mode_set_R3:   assert property (@(posedge clk) disable iff (rst) reserved_wr |=> bad_mode);
  assert_bad_mode_clr_R3:   assert property (@(posedge clk) disable iff (rst) !reserved_wr |=> !bad_mode);
  assert_target_aligned_R4: assert property (@(posedge clk) disable iff (rst) redirect |-> (redirect_lo == 2'b00));
  assert_unmapped_zero_R9:  assert property (@(posedge clk) disable iff (rst) unmapped |=> (rdata == '0));
endmodule

bind trap_dispatch_unit trap_dispatch_unit_checker #(
  .XLEN(XLEN), .AW(AW), .ADDR_VEC(ADDR_VEC), .ADDR_CAUSE(ADDR_CAUSE), .ADDR_EPC(ADDR_EPC)
) u_chk (
  .clk(clk), .rst(rst), .csr_addr(csr_addr_i), .csr_we(csr_we_i), .wmode_hi(csr_wdata_i[1]),
  .trap(trap_i), .redirect(redirect_o), .redirect_lo(redirect_pc_o[1:0]),
  .bad_mode(bad_mode_o), .rdata(csr_rdata_o)
);

// File: tb/trap_dispatch_unit_bench.sv
`timescale 1ns/1ps
module trap_dispatch_unit_bench;
  localparam logic [11:0] A_VEC = 12'h305, A_CAUSE = 12'h342, A_EPC = 12'h341;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_rdata;
  logic        trap = 1'b0;
  logic        trap_irq = 1'b0;
  logic [30:0] trap_code = '0;
  logic [31:0] trap_pc = '0;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic        bad_mode;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_vec = '0, m_cause = '0, m_epc = '0;

  always #4 clk = ~clk;

  trap_dispatch_unit u_trap_dispatch_unit (
    .clk(clk), .rst(rst), .csr_addr_i(csr_addr), .csr_wdata_i(csr_wdata), .csr_we_i(csr_we),
    .csr_rdata_o(csr_rdata), .trap_i(trap), .trap_irq_i(trap_irq), .trap_code_i(trap_code),
    .trap_pc_i(trap_pc), .redirect_o(redirect), .redirect_pc_o(redirect_pc), .bad_mode_o(bad_mode)
  );

  function automatic logic [31:0] f_target(logic [31:0] v, logic irq, logic [30:0] code);
    logic [31:0] b = {v[31:2], 2'b00};
    if (v[1:0] == 2'd1 && irq) return b + {code[29:0], 2'b00};
    return b;
  endfunction

  function automatic logic [31:0] f_read(logic [11:0] a);
    if (a == A_VEC)   return m_vec;
    if (a == A_CAUSE) return m_cause;
    if (a == A_EPC)   return m_epc;
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; results checked one edge later.
  task automatic cycle(string rtag, logic we, logic [11:0] a, logic [31:0] wd,
                       logic tr, logic irq, logic [30:0] code, logic [31:0] pc);
    logic [31:0] e_rd, e_tgt;
    logic        e_bad;
    string       ttag;
    csr_we = we; csr_addr = a; csr_wdata = wd;
    trap = tr; trap_irq = irq; trap_code = code; trap_pc = pc;
    e_rd  = f_read(a);
    e_tgt = f_target(m_vec, irq, code);
    e_bad = we && a == A_VEC && wd[1];
    ttag  = (m_vec[1:0] == 2'd0) ? "R4" : (irq ? "R5" : "R6");
    if (we && a == A_VEC) m_vec = wd[1] ? {wd[31:2], m_vec[1:0]} : wd;
    if (tr) begin
      m_cause = {irq, code};
      m_epc   = {pc[31:2], 2'b00};
    end else if (we) begin
      if (a == A_CAUSE) m_cause = wd;
      if (a == A_EPC)   m_epc   = {wd[31:2], 2'b00};
    end
    @(posedge clk);
    @(negedge clk);
    check("R7 redirect", {31'b0, redirect}, {31'b0, tr});
    if (tr) check(ttag, redirect_pc, e_tgt);
    check("R3 bad_mode", {31'b0, bad_mode}, {31'b0, e_bad});
    if (a != A_VEC && a != A_CAUSE && a != A_EPC) check("R9 unmapped read", csr_rdata, e_rd);
    else check(rtag, csr_rdata, e_rd);
  endtask

  task automatic rd(string t, logic [11:0] a);
    cycle(t, 1'b0, a, 32'h0, 1'b0, 1'b0, 31'h0, 32'h0);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    cycle("R10", 1'b1, a, d, 1'b0, 1'b0, 31'h0, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 redirect", {31'b0, redirect}, 32'h0);
    check("R1 bad_mode", {31'b0, bad_mode}, 32'h0);
    check("R1 rdata", csr_rdata, 32'h0);
    rd("R1 vec", A_VEC); rd("R1 cause", A_CAUSE); rd("R1 epc", A_EPC);
    rd("R1 vec again", A_VEC);
    // R2: legal vectored write
    wr(A_VEC, 32'h1000_0001); rd("R2 vec", A_VEC);
    // R5 / R7: vectored interrupt
    cycle("R10", 1'b0, A_CAUSE, 32'h0, 1'b1, 1'b1, 31'd7, 32'h0000_4567);
    rd("R7 cause", A_CAUSE); rd("R7 epc", A_EPC);
    // R6: vectored exception
    cycle("R10", 1'b0, A_VEC, 32'h0, 1'b1, 1'b0, 31'd2, 32'h0000_1000);
    // R3: reserved style kept out
    wr(A_VEC, 32'h2000_0003); rd("R3 vec", A_VEC);
    wr(A_VEC, 32'h3000_0002); rd("R3 vec", A_VEC);
    // R4: direct style ignores the code
    wr(A_VEC, 32'h2000_0000);
    cycle("R10", 1'b0, A_VEC, 32'h0, 1'b1, 1'b1, 31'd5, 32'h8);
    // R8: trap beats CSR write
    cycle("R10", 1'b1, A_CAUSE, 32'hDEAD_BEEF, 1'b1, 1'b0, 31'd11, 32'hABCD_0003);
    rd("R8 cause", A_CAUSE);
    cycle("R10", 1'b1, A_EPC, 32'h1111_1110, 1'b1, 1'b1, 31'd3, 32'h2222_2222);
    rd("R8 epc", A_EPC);
    // R11: exception-PC write alignment
    wr(A_EPC, 32'h0000_1237); rd("R11 epc", A_EPC);
    // R9: unmapped write leaves registers alone
    wr(12'h123, 32'hFFFF_FFFF); rd("R9 vec", A_VEC); rd("R9 cause", A_CAUSE); rd("R9 epc", A_EPC);
    // R5: wrap around
    wr(A_VEC, 32'hFFFF_FFF1);
    cycle("R10", 1'b0, A_VEC, 32'h0, 1'b1, 1'b1, 31'd4, 32'h0);
    cycle("R10", 1'b0, A_VEC, 32'h0, 1'b1, 1'b1, 31'h7FFF_FFFF, 32'h0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [11:0] a;
      int unsigned sel = $urandom % 4;
      a = (sel == 0) ? A_VEC : (sel == 1) ? A_CAUSE : (sel == 2) ? A_EPC : 12'($urandom);
      cycle("R10", ($urandom % 10) < 3, a, $urandom, ($urandom % 4) == 0,
            1'($urandom), 31'($urandom % 64), $urandom);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule